// File: doc/BRIEF.md
# Intra-Field Line-Doubling Deinterlacer

This block turns an interlaced stream of 24-bit RGB pixels into progressive frames. Each field line that arrives is written into one of two alternating line banks. Once a line is complete, the block produces the output lines that depend on it. Every field of N lines becomes one output frame of 2N lines. Half of the output lines are copies of field lines. The other half are filled by averaging the two vertically adjacent lines of the same field. Lines from the opposite field are never mixed in.

The input is a valid/ready stream carrying pixel data, a line-start flag, a field-start flag and a field number. A beat transfers on a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must hold every input steady. `in_ready` falls for the whole time the block is producing output lines from the line just received, and it rises again once they have been sent. A field of N lines of L pixels therefore holds `in_ready` low for 2N·L cycles against N·L accepting cycles. The output has no back-pressure: a beat is meaningful only while `out_valid` is high.

Line length and lines per field come from runtime inputs, which are captured at the first field start after reset. A parameter selects whether every field makes a frame or only fields of one polarity do. A second parameter picks which field number counts as the even field.

Top module: `field_doubler`

## Requirements
- R1: An input beat is taken only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low in every cycle in which an output pixel is being produced, so `out_valid` is never high in the cycle after one in which `in_ready` was high.
- R2: After reset, accepted beats are discarded until one arrives with `in_vsync` high. No output appears before that beat.
- R3: A field of N lines, each `line_len` pixels long, yields exactly 2N output lines of `line_len` pixels. The first pixel of each input line carries `in_hsync` high. `line_len` must not exceed the line bank depth 2^ADDR_W.
- R4: An interpolated pixel is the per-channel average (a+b+1)>>1 of the two source pixels, where the channels are the 8-bit fields at bits [23:16], [15:8] and [7:0].
- R5: For an even field (`in_field` equal to EVEN_ID), output line 2k is field line k. Output line 2k+1 is the average of lines k and k+1. The last output line repeats line N-1.
- R6: For an odd field, output line 0 is field line 0. Output line 2k (k>0) is the average of lines k-1 and k. Output line 2k+1 is line k.
- R7: `out_vsync` is high only on the first pixel of each output frame. `out_hsync` is high on the first pixel of each output line. Both are high only together with `out_valid`.
- R8: With FULL_RATE=1, every field, whatever its polarity, produces a frame.
- R9: With FULL_RATE=0, fields whose `in_field` differs from EVEN_ID are accepted at the normal rate but produce no output.
- R10: `line_len` and `field_lines` are captured at the first accepted field start after reset. Later changes to them have no effect until the next reset.
- R11: `rst_n` is asynchronous and active low. While it is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_len | input | 12 | Pixels per input line |
| field_lines | input | 12 | Lines per input field |
| in_pix | input | 24 | Input pixel, R/G/B at [23:16]/[15:8]/[7:0] |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_vsync | input | 1 | First pixel of a field |
| in_hsync | input | 1 | First pixel of a line |
| in_field | input | 1 | Field number, qualified with the field start |
| out_pix | output | 24 | Output pixel |
| out_valid | output | 1 | Output beat valid |
| out_vsync | output | 1 | First pixel of an output frame |
| out_hsync | output | 1 | First pixel of an output line |

## Verification
The accepting edge of a line's last pixel moves the sequencer into emission. The first pixel of that line's first output line is registered on the next edge, and the rest follow one per clock with no gaps until the line group ends. Every result therefore lags its emission cycle by exactly one register. The bench collects each `out_valid` beat at the falling edge in arrival order and compares the whole frame against a model built from R4 to R6, rather than counting cycles to each pixel. It lets each field drain longer than 2N·L cycles before comparing. The handshake rule is checked one cycle apart: the `in_ready` level sampled at the previous falling edge is compared with `out_valid` at the current one.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int CH_W   = 8;
  localparam int CHANS  = 3;
  localparam int PIX_W  = CH_W * CHANS;
  localparam int SIZE_W = 12;

  typedef enum logic [1:0] {
    ST_SEEK = 2'd0,
    ST_RECV = 2'd1,
    ST_EMIT = 2'd2
  } fd_state_e;
endpackage

// File: rtl/fd_blend.sv
module fd_blend #(
  parameter int CH_W  = 8,
  parameter int CHANS = 3
) (
  input  logic [CH_W*CHANS-1:0] a_i,
  input  logic [CH_W*CHANS-1:0] b_i,
  output logic [CH_W*CHANS-1:0] y_o
);
  for (genvar c = 0; c < CHANS; c++) begin : g_ch
    logic [CH_W-1:0] a_c, b_c, y_c;
    logic [CH_W:0]   sum_c;
    assign a_c   = a_i[c*CH_W +: CH_W];
    assign b_c   = b_i[c*CH_W +: CH_W];
    assign sum_c = {1'b0, a_c} + {1'b0, b_c} + {{CH_W{1'b0}}, 1'b1};
    assign y_c   = sum_c[CH_W:1];
    assign y_o[c*CH_W +: CH_W] = y_c;

    // R4: rounded mean always lies between its two operands
    always_comb begin
      assert_avg_range_R4: assert ((y_c >= ((a_c < b_c) ? a_c : b_c)) &&
                                   (y_c <= ((a_c < b_c) ? b_c : a_c)))
        else $error("channel average outside operand range");
    end
  end
endmodule

// File: rtl/fd_line_mem.sv
module fd_line_mem #(
  parameter int ADDR_W = 4,
  parameter int W      = 24
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      cur_o,
  output logic [W-1:0]      prev_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BANKS = 2;

  logic [W-1:0] bank_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [W-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) store[wr_addr] <= wr_data;
    end
    assign bank_q[b] = store[rd_addr];
  end

  assign cur_o  = bank_q[rd_bank];
  assign prev_o = bank_q[~rd_bank];
endmodule

// File: rtl/fd_seq.sv
module fd_seq
  import fd_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter bit FULL_RATE = 1'b1,
  parameter bit EVEN_ID   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] len_i,
  input  logic [SIZE_W-1:0] lines_i,
  input  logic              in_valid,
  input  logic              in_vsync,
  input  logic              in_hsync,
  input  logic              in_field,
  output logic              in_ready,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_bank,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              emit_valid,
  output logic              emit_avg,
  output logic              emit_vsync,
  output logic              emit_hsync
);
  localparam int DEPTH = 1 << ADDR_W;

  fd_state_e         st;
  logic              started;
  logic [SIZE_W-1:0] cfg_len, cfg_lines;
  logic [SIZE_W-1:0] pix_cnt, line_cnt;
  logic              even_q, drop_q;
  logic [1:0]        emit_j;

  logic [SIZE_W-1:0] len_eff, lines_eff, idx, lidx;
  logic              accept, field_start, take, f_even, f_drop;
  logic              line_end, field_last;
  logic              first_line, last_line, pix_end;
  logic [1:0]        emit_cnt;

  always_comb begin
    len_eff     = started ? cfg_len : len_i;
    lines_eff   = started ? cfg_lines : lines_i;
    in_ready    = (st != ST_EMIT);
    accept      = in_valid && in_ready;
    field_start = accept && (st == ST_SEEK) && in_vsync;
    take        = field_start || (accept && (st == ST_RECV));
    idx         = (st == ST_SEEK) ? '0 : pix_cnt;
    lidx        = (st == ST_SEEK) ? '0 : line_cnt;
    f_even      = (st == ST_SEEK) ? (in_field == EVEN_ID) : even_q;
    f_drop      = (st == ST_SEEK) ? (!FULL_RATE && (in_field != EVEN_ID)) : drop_q;
    line_end    = take && (idx == len_eff - SIZE_W'(1));
    field_last  = (lidx == lines_eff - SIZE_W'(1));

    wr_en   = take;
    wr_bank = lidx[0];
    wr_addr = idx[ADDR_W-1:0];

    first_line = (line_cnt == '0);
    last_line  = (line_cnt == cfg_lines - SIZE_W'(1));
    pix_end    = (pix_cnt == cfg_len - SIZE_W'(1));
    emit_cnt   = 2'd2 - {1'b0, first_line && even_q} + {1'b0, last_line && even_q};

    emit_valid = (st == ST_EMIT);
    emit_avg   = emit_valid && (emit_j == 2'd0) && !first_line;
    emit_hsync = emit_valid && (pix_cnt == '0);
    emit_vsync = emit_hsync && (emit_j == 2'd0) && first_line;
    rd_addr    = pix_cnt[ADDR_W-1:0];
    rd_bank    = line_cnt[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_SEEK;
      started   <= 1'b0;
      cfg_len   <= '0;
      cfg_lines <= '0;
      pix_cnt   <= '0;
      line_cnt  <= '0;
      even_q    <= 1'b0;
      drop_q    <= 1'b0;
      emit_j    <= 2'd0;
    end else begin
      if (field_start) begin
        if (!started) begin
          started   <= 1'b1;
          cfg_len   <= len_i;
          cfg_lines <= lines_i;
        end
        even_q <= f_even;
        drop_q <= f_drop;
      end
      if (take) begin
        if (line_end) begin
          pix_cnt <= '0;
          if (f_drop) begin
            if (field_last) begin
              st <= ST_SEEK;
            end else begin
              st       <= ST_RECV;
              line_cnt <= lidx + SIZE_W'(1);
            end
          end else begin
            st       <= ST_EMIT;
            line_cnt <= lidx;
            emit_j   <= 2'd0;
          end
        end else begin
          st       <= ST_RECV;
          pix_cnt  <= idx + SIZE_W'(1);
          line_cnt <= lidx;
        end
      end
      if (st == ST_EMIT) begin
        if (pix_end) begin
          pix_cnt <= '0;
          if (emit_j == emit_cnt - 2'd1) begin
            emit_j <= 2'd0;
            if (last_line) begin
              st <= ST_SEEK;
            end else begin
              st       <= ST_RECV;
              line_cnt <= line_cnt + SIZE_W'(1);
            end
          end else begin
            emit_j <= emit_j + 2'd1;
          end
        end else begin
          pix_cnt <= pix_cnt + SIZE_W'(1);
        end
      end
    end
  end

  // R10: captured sizes never move once processing has begun
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(started) |-> ($stable(cfg_len) && $stable(cfg_lines)));

  // R3: each stored pixel fits the line bank
  assert_addr_fit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ({1'b0, idx} < (SIZE_W+1)'(DEPTH)));

  // R3: the first stored pixel of every line arrives flagged as a line start
  assert_line_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (idx == '0)) |-> in_hsync);

  // R9: a discarded field never enters emission
  assert_drop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RECV) && drop_q) |=> (st != ST_EMIT));
endmodule

// File: rtl/field_doubler.sv
module field_doubler
  import fd_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter bit FULL_RATE = 1'b1,
  parameter bit EVEN_ID   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] line_len,
  input  logic [SIZE_W-1:0] field_lines,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_vsync,
  input  logic              in_hsync,
  input  logic              in_field,
  output logic [PIX_W-1:0]  out_pix,
  output logic              out_valid,
  output logic              out_vsync,
  output logic              out_hsync
);
  logic              wr_en, wr_bank, rd_bank;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              emit_valid, emit_avg, emit_vsync, emit_hsync;
  logic [PIX_W-1:0]  cur_pix, prev_pix, mean_pix;

  fd_seq #(
    .ADDR_W   (ADDR_W),
    .FULL_RATE(FULL_RATE),
    .EVEN_ID  (EVEN_ID)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_i     (line_len),
    .lines_i   (field_lines),
    .in_valid  (in_valid),
    .in_vsync  (in_vsync),
    .in_hsync  (in_hsync),
    .in_field  (in_field),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_bank   (wr_bank),
    .wr_addr   (wr_addr),
    .rd_bank   (rd_bank),
    .rd_addr   (rd_addr),
    .emit_valid(emit_valid),
    .emit_avg  (emit_avg),
    .emit_vsync(emit_vsync),
    .emit_hsync(emit_hsync)
  );

  fd_line_mem #(
    .ADDR_W(ADDR_W),
    .W     (PIX_W)
  ) u_mem (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_bank(wr_bank),
    .wr_addr(wr_addr),
    .wr_data(in_pix),
    .rd_bank(rd_bank),
    .rd_addr(rd_addr),
    .cur_o  (cur_pix),
    .prev_o (prev_pix)
  );

  fd_blend #(
    .CH_W (CH_W),
    .CHANS(CHANS)
  ) u_blend (
    .a_i(prev_pix),
    .b_i(cur_pix),
    .y_o(mean_pix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pix   <= '0;
      out_valid <= 1'b0;
      out_vsync <= 1'b0;
      out_hsync <= 1'b0;
    end else begin
      out_pix   <= emit_avg ? mean_pix : cur_pix;
      out_valid <= emit_valid;
      out_vsync <= emit_vsync;
      out_hsync <= emit_hsync;
    end
  end

  // R1: output only follows a cycle in which input was held off
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready));

  // R7: frame start is also a line start and a valid beat
  assert_frame_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_vsync |-> (out_hsync && out_valid));

  // R7: line start only on a valid beat
  assert_line_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_hsync |-> out_valid);
endmodule

// File: tb/field_doubler_tb.sv
module field_doubler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] len_in = 12'd5, lines_in = 12'd3;
  logic [23:0] pix = '0;
  logic        vs = 1'b0, hs = 1'b0, fid = 1'b0, va = 1'b0, vb = 1'b0;
  logic        rdy_a, rdy_b, ov_a, ov_b, ovs_a, ovs_b, ohs_a, ohs_b;
  logic [23:0] op_a, op_b;

  int errs = 0, checks = 0, hs_err = 0;
  logic [23:0] ga_pix [0:1023];
  logic        ga_vs [0:1023], ga_hs [0:1023];
  logic [23:0] gb_pix [0:1023];
  logic        gb_vs [0:1023], gb_hs [0:1023];
  int na = 0, nb = 0;
  logic prev_rdy_a = 1'b1, prev_rdy_b = 1'b1;

  always #5 clk = ~clk;

  field_doubler #(.ADDR_W(3), .FULL_RATE(1'b1), .EVEN_ID(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_len(len_in), .field_lines(lines_in),
    .in_pix(pix), .in_valid(va), .in_ready(rdy_a), .in_vsync(vs), .in_hsync(hs),
    .in_field(fid), .out_pix(op_a), .out_valid(ov_a), .out_vsync(ovs_a), .out_hsync(ohs_a));

  field_doubler #(.ADDR_W(3), .FULL_RATE(1'b0), .EVEN_ID(1'b1)) u_dut_half (
    .clk(clk), .rst_n(rst_n), .line_len(len_in), .field_lines(lines_in),
    .in_pix(pix), .in_valid(vb), .in_ready(rdy_b), .in_vsync(vs), .in_hsync(hs),
    .in_field(fid), .out_pix(op_b), .out_valid(ov_b), .out_vsync(ovs_b), .out_hsync(ohs_b));

  // field table: [9] field number, [8] full-rate unit expects a frame,
  // [7] half-rate unit expects a frame, [6:0] pixel seed
  localparam logic [9:0] TBL [0:5] = '{
    {1'b0, 1'b1, 1'b0, 7'd1},
    {1'b1, 1'b1, 1'b1, 7'd2},
    {1'b0, 1'b1, 1'b0, 7'd3},
    {1'b1, 1'b1, 1'b1, 7'd4},
    {1'b1, 1'b1, 1'b1, 7'd5},
    {1'b0, 1'b1, 1'b0, 7'd6}
  };

  always @(negedge clk) begin
    if (ov_a) begin
      ga_pix[na] = op_a; ga_vs[na] = ovs_a; ga_hs[na] = ohs_a; na++;
      if (prev_rdy_a) hs_err++;
    end
    if (ov_b) begin
      gb_pix[nb] = op_b; gb_vs[nb] = ovs_b; gb_hs[nb] = ohs_b; nb++;
      if (prev_rdy_b) hs_err++;
    end
    prev_rdy_a = rdy_a;
    prev_rdy_b = rdy_b;
  end

  function automatic logic [23:0] src_pix(int seed, int k, int p);
    logic [7:0] r, g, b;
    r = 8'(seed * 29 + k * 71 + p * 13);
    g = 8'(seed * 5 + k * 200 + p * 3 + 1);
    b = 8'(255 - seed * 17 - k * 9 - p * 41);
    return {r, g, b};
  endfunction

  function automatic logic [23:0] mean24(logic [23:0] x, logic [23:0] y);
    logic [23:0] r;
    for (int c = 0; c < 3; c++) begin
      int s;
      s = int'(x[c*8 +: 8]) + int'(y[c*8 +: 8]) + 1;
      r[c*8 +: 8] = 8'(s >> 1);
    end
    return r;
  endfunction

  function automatic logic [23:0] exp_pix(bit even, int seed, int m, int p, int nl);
    int k;
    k = m / 2;
    if (even) begin
      if (m % 2 == 0) return src_pix(seed, k, p);
      if (k + 1 < nl) return mean24(src_pix(seed, k, p), src_pix(seed, k + 1, p));
      return src_pix(seed, k, p);
    end
    if (m % 2 == 1) return src_pix(seed, k, p);
    if (m == 0) return src_pix(seed, 0, p);
    return mean24(src_pix(seed, k - 1, p), src_pix(seed, k, p));
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic send_beat(logic [23:0] d, logic v, logic h, logic f);
    pix = d; vs = v; hs = h; fid = f; va = 1'b1; vb = 1'b1;
    while (va || vb) begin
      bit ta, tb;
      ta = va && rdy_a;
      tb = vb && rdy_b;
      @(posedge clk);
      @(negedge clk);
      if (ta) va = 1'b0;
      if (tb) vb = 1'b0;
    end
  endtask

  task automatic send_field(logic f, int seed, int len, int nl);
    for (int k = 0; k < nl; k++)
      for (int p = 0; p < len; p++)
        send_beat(src_pix(seed, k, p), (k == 0) && (p == 0), p == 0, f);
  endtask

  task automatic check_frame(bit is_a, int base, bit on, bit even, int seed,
                             int len, int nl, string tag);
    int n, expn, bad_i, bad_s;
    logic [23:0] got, want, bad_g, bad_w;
    logic gv, gh;
    n = is_a ? (na - base) : (nb - base);
    expn = on ? 2 * nl * len : 0;
    check(n == expn, tag, "output pixel count", n, expn);
    if (on && n == expn) begin
      bad_i = -1; bad_s = -1; bad_g = '0; bad_w = '0;
      for (int i = 0; i < n; i++) begin
        got  = is_a ? ga_pix[base + i] : gb_pix[base + i];
        gv   = is_a ? ga_vs[base + i] : gb_vs[base + i];
        gh   = is_a ? ga_hs[base + i] : gb_hs[base + i];
        want = exp_pix(even, seed, i / len, i % len, nl);
        if (got !== want && bad_i < 0) begin bad_i = i; bad_g = got; bad_w = want; end
        if ((gv !== (i == 0) || gh !== ((i % len) == 0)) && bad_s < 0) bad_s = i;
      end
      check(bad_i < 0, even ? "R5/R4" : "R6/R4", "frame pixel data", int'(bad_g), int'(bad_w));
      check(bad_s < 0, "R7", "sync flag position", bad_s, -1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R1 watchdog: actual hang expected completion");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int ba, bb;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(rdy_a && rdy_b, "R11", "ready in reset", {rdy_a, rdy_b}, 3);
    check(!ov_a && !ov_b, "R11", "valid in reset", {ov_a, ov_b}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: beats before any field start are discarded
    for (int i = 0; i < 4; i++) send_beat(24'h00A5A5 + 24'(i), 1'b0, 1'b1, 1'b0);
    repeat (30) @(negedge clk);
    check(na == 0 && nb == 0, "R2", "output before field start", na + nb, 0);

    // table walk: R3 R5 R6 R8 R9
    for (int t = 0; t < 6; t++) begin
      ba = na; bb = nb;
      send_field(TBL[t][9], int'(TBL[t][6:0]), 5, 3);
      repeat (3 * 3 * 5 + 6) @(negedge clk);
      check_frame(1'b1, ba, TBL[t][8], TBL[t][9] == 1'b0, int'(TBL[t][6:0]), 5, 3, "R3/R8");
      check_frame(1'b0, bb, TBL[t][7], TBL[t][9] == 1'b1, int'(TBL[t][6:0]), 5, 3, "R9");
    end

    // R10: size inputs change, captured size stays in force
    len_in = 12'd7; lines_in = 12'd2;
    ba = na; bb = nb;
    send_field(1'b0, 20, 5, 3);
    repeat (3 * 3 * 5 + 6) @(negedge clk);
    check_frame(1'b1, ba, 1'b1, 1'b1, 20, 5, 3, "R10");
    check_frame(1'b0, bb, 1'b0, 1'b0, 20, 5, 3, "R9");

    // R11: asynchronous reset in the middle of emission
    send_field(1'b0, 21, 5, 3);
    repeat (2) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check(!ov_a, "R11", "valid after async reset", ov_a, 0);
    check(rdy_a, "R11", "ready after async reset", rdy_a, 1);
    len_in = 12'd6; lines_in = 12'd2;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // new size after reset, odd field for the full-rate unit, even for the other
    ba = na; bb = nb;
    send_field(1'b1, 30, 6, 2);
    repeat (3 * 2 * 6 + 6) @(negedge clk);
    check_frame(1'b1, ba, 1'b1, 1'b0, 30, 6, 2, "R10/R6");
    check_frame(1'b0, bb, 1'b1, 1'b1, 30, 6, 2, "R9/R5");

    // R1: no output in a cycle following ready high
    check(hs_err == 0, "R1", "output after ready high", hs_err, 0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule